// File: doc/BRIEF.md
# Software Write-Protect Controller

This block keeps the write-protect state of a 256-byte serial memory. For every command that the bus front end decodes, it decides whether to acknowledge. For array writes it also decides whether each data byte may reach the array. It accepts a stream of already decoded events: a control byte with its code, chip-select bits and direction, the word-address byte, data bytes and the Stop condition. It also samples the levels on the three address pins, a high-voltage detect flag on address pin 0, and the hardware protect pin. Bit timing on the wire and the storage array lie outside the block.

There are three protection levels: none, soft (clearable), and permanent lock. The soft and permanent levels cover the lower half of the array. The hardware protect pin covers the whole array and overrides the software levels. The soft level is set and cleared by protect commands that need high voltage on address pin 0. The lock is one-way. Once it is set, the block no longer answers the protect control code. Any accepted write that carried data starts a self-timed write cycle on Stop. While that cycle runs, nothing is acknowledged. A pending change to the protect state takes effect when the cycle ends, and a one-cycle update strobe marks that moment.

The protect bits model non-volatile cells. The reset loads them from the `init_soft` and `init_perm` image inputs.

Top module: `swp_ctrl`

## Requirements
- R1: Reset loads the soft and lock bits from `init_soft`/`init_perm`. It clears the session, the timer and all strobes, so every output reads 0 after reset.
- R2: A control byte with code 1010 whose chip-select field (`ctl_cs` = {A2,A1,A0}) equals {`pin_a2`,`pin_a1`,`pin_a0`} is acknowledged on `ctl_ack` one cycle after `ctl_valid`. With any other chip-select value it is not acknowledged.
- R3: After an acknowledged array write, each data byte raises `data_ack` one cycle later and presents `wr_addr`. The address starts at the address byte. Its 4 low bits increment after each byte and wrap inside the 16-byte page, and its upper bits stay fixed.
- R4: When the soft or lock bit is set, writes to 00h-7Fh still have their control, address and data bytes acknowledged, but `wr_en` stays low. Writes to 80h-FFh raise `wr_en`.
- R5: While `hw_wp` is high, `wr_en` never rises for any address. The acknowledges and the write cycle proceed as they would without protection.
- R6: A Stop after an accepted write that carried at least one data byte raises `busy` for exactly WR_CYCLES cycles. A Stop with no data byte starts no cycle. While `busy` is high, no control byte is acknowledged.
- R7: Set-protect has code 0110, chip-select 001, `a0_hv`=1 and `pin_a1`=`pin_a2`=0, sent with R/W=0. It is acknowledged and starts a cycle when the soft bit is clear. When the soft bit is already set, it is not acknowledged, and its address byte and Stop have no effect.
- R8: Clear-protect has code 0110, chip-select 011, `a0_hv`=1, `pin_a1`=1 and `pin_a2`=0. It is acknowledged and clears the soft bit at the end of its cycle.
- R9: Lock has code 0110, chip-select equal to the pins and `a0_hv`=0. Once the lock bit is set, no control byte with code 0110 is acknowledged and the lock bit never clears until the next reset.
- R10: A code-0110 control byte sent with R/W=1 reports status through its acknowledge. The lock bit set means no acknowledge. The soft bit set means set-protect is not acknowledged while clear and lock are. With no protection, all three are acknowledged. A status query starts no cycle.
- R11: A protect command changes the protect bits only at the end of its write cycle. `reg_upd` pulses for one cycle in the cycle in which `busy` falls.
- R12: Address and data bytes that follow a control byte that was not acknowledged are not acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| init_soft | input | 1 | Stored soft-protect bit, loaded on reset |
| init_perm | input | 1 | Stored lock bit, loaded on reset |
| ctl_valid | input | 1 | Control byte received |
| ctl_code | input | 4 | Control code field of the control byte |
| ctl_cs | input | 3 | Chip-select field {A2,A1,A0} |
| ctl_rw | input | 1 | Direction bit, 1 = read |
| addr_valid | input | 1 | Word-address byte received |
| addr_byte | input | ADDR_W | Word-address byte |
| data_valid | input | 1 | Write data byte received |
| stop_seen | input | 1 | Stop condition seen |
| pin_a0 | input | 1 | Logic level on address pin 0 |
| pin_a1 | input | 1 | Logic level on address pin 1 |
| pin_a2 | input | 1 | Logic level on address pin 2 |
| a0_hv | input | 1 | High voltage detected on address pin 0 |
| hw_wp | input | 1 | Hardware protect pin, 1 = whole array protected |
| ctl_ack | output | 1 | Acknowledge for the last control byte |
| addr_ack | output | 1 | Acknowledge for the address byte |
| data_ack | output | 1 | Acknowledge for a data byte |
| wr_en | output | 1 | Data byte may be stored at `wr_addr` |
| wr_addr | output | ADDR_W | Target address of the current data byte |
| busy | output | 1 | Self-timed write cycle running |
| reg_upd | output | 1 | Protect bits updated this cycle |

## Verification
The assertions check on every cycle that nothing is acknowledged during a write cycle and that code 0110 goes unanswered once locked. They also check that `wr_en` never fires into a region the hardware pin or the software bits protected, that the lock bit never falls, and that the soft bit moves only with the update strobe as `busy` falls. Only the bench scenarios can show the rest: the exact acknowledge pattern of each protect command and status query in each state, page wrap of the write address, the exact cycle length, and the absence of a cycle after a Stop with no data or a rejected command.

// File: rtl/swp_pkg.sv
package swp_pkg;

  typedef enum logic [2:0] {
    K_NONE,
    K_ARR_WR,
    K_ARR_RD,
    K_SET,
    K_CLR,
    K_PERM,
    K_QUERY
  } cmd_kind_e;

  localparam logic [3:0] CODE_ARRAY = 4'b1010;
  localparam logic [3:0] CODE_PROT  = 4'b0110;
  localparam logic [2:0] CS_SET     = 3'b001;
  localparam logic [2:0] CS_CLR     = 3'b011;

  function automatic logic takes_data(cmd_kind_e k);
    return (k == K_ARR_WR) || (k == K_SET) || (k == K_CLR) || (k == K_PERM);
  endfunction

  function automatic logic is_prot_op(cmd_kind_e k);
    return (k == K_SET) || (k == K_CLR) || (k == K_PERM);
  endfunction

endpackage

// File: rtl/swp_cmd_decode.sv
module swp_cmd_decode
  import swp_pkg::*;
(
  input  logic [3:0] code,
  input  logic [2:0] cs,
  input  logic       rw,
  input  logic       pin_a0,
  input  logic       pin_a1,
  input  logic       pin_a2,
  input  logic       a0_hv,
  input  logic       soft_q,
  input  logic       perm_q,
  input  logic       busy,
  output logic       ack,
  output cmd_kind_e  kind
);

  logic [2:0] pins;
  logic       set_pat;
  logic       clr_pat;
  logic       lock_pat;

  assign pins     = {pin_a2, pin_a1, pin_a0};
  assign set_pat  = (cs == CS_SET) && a0_hv && !pin_a1 && !pin_a2;
  assign clr_pat  = (cs == CS_CLR) && a0_hv && pin_a1 && !pin_a2;
  assign lock_pat = !a0_hv && (cs == pins);

  always_comb begin
    ack  = 1'b0;
    kind = K_NONE;
    if (!busy) begin
      if (code == CODE_ARRAY && cs == pins) begin
        ack  = 1'b1;
        kind = rw ? K_ARR_RD : K_ARR_WR;
      end else if (code == CODE_PROT && !perm_q) begin
        if (set_pat) begin
          ack  = !soft_q;
          kind = rw ? K_QUERY : K_SET;
        end else if (clr_pat) begin
          ack  = 1'b1;
          kind = rw ? K_QUERY : K_CLR;
        end else if (lock_pat) begin
          ack  = 1'b1;
          kind = rw ? K_QUERY : K_PERM;
        end
      end
    end
  end

endmodule

// File: rtl/swp_wcycle_timer.sv
module swp_wcycle_timer #(
  parameter int CYCLES = 24
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy,
  output logic last
);

  localparam int CNT_W = $clog2(CYCLES + 1);

  logic [CNT_W-1:0] cnt;

  assign last = busy && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start && !busy) begin
      busy <= 1'b1;
      cnt  <= CNT_W'(CYCLES - 1);
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end
  end

endmodule

// File: rtl/swp_prot_reg.sv
module swp_prot_reg
  import swp_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      init_soft,
  input  logic      init_perm,
  input  logic      apply,
  input  cmd_kind_e op,
  output logic      soft_q,
  output logic      perm_q,
  output logic      upd
);

  always_ff @(posedge clk) begin
    if (rst) begin
      soft_q <= init_soft;
      perm_q <= init_perm;
      upd    <= 1'b0;
    end else begin
      upd <= apply && is_prot_op(op);
      if (apply) begin
        case (op)
          K_SET:   soft_q <= 1'b1;
          K_CLR:   if (!perm_q) soft_q <= 1'b0;
          K_PERM:  perm_q <= 1'b1;
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/swp_page_ptr.sv
module swp_page_ptr #(
  parameter int ADDR_W = 8,
  parameter int PAGE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              step,
  output logic [ADDR_W-1:0] ptr
);

  logic [PAGE_W-1:0] low_next;
  assign low_next = ptr[PAGE_W-1:0] + 1'b1;

  generate
    if (PAGE_W < ADDR_W) begin : g_split
      always_ff @(posedge clk) begin
        if (rst)       ptr <= '0;
        else if (load) ptr <= load_val;
        else if (step) ptr <= {ptr[ADDR_W-1:PAGE_W], low_next};
      end
    end else begin : g_whole
      always_ff @(posedge clk) begin
        if (rst)       ptr <= '0;
        else if (load) ptr <= load_val;
        else if (step) ptr <= low_next;
      end
    end
  endgenerate

endmodule

// File: rtl/swp_ctrl.sv
module swp_ctrl
  import swp_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int PAGE_W    = 4,
  parameter int WR_CYCLES = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              init_soft,
  input  logic              init_perm,
  input  logic              ctl_valid,
  input  logic [3:0]        ctl_code,
  input  logic [2:0]        ctl_cs,
  input  logic              ctl_rw,
  input  logic              addr_valid,
  input  logic [ADDR_W-1:0] addr_byte,
  input  logic              data_valid,
  input  logic              stop_seen,
  input  logic              pin_a0,
  input  logic              pin_a1,
  input  logic              pin_a2,
  input  logic              a0_hv,
  input  logic              hw_wp,
  output logic              ctl_ack,
  output logic              addr_ack,
  output logic              data_ack,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic              busy,
  output logic              reg_upd
);

  localparam int HALF_BIT = ADDR_W - 1;

  cmd_kind_e         dec_kind;
  logic              dec_ack;
  cmd_kind_e         sess;
  cmd_kind_e         pend_op;
  logic              got_addr;
  logic              got_data;
  logic              soft_q;
  logic              perm_q;
  logic              cyc_last;
  logic [ADDR_W-1:0] ptr;
  logic              addr_take;
  logic              data_take;
  logic              start_cyc;
  logic              blocked;

  swp_cmd_decode u_dec (
    .code   (ctl_code),
    .cs     (ctl_cs),
    .rw     (ctl_rw),
    .pin_a0 (pin_a0),
    .pin_a1 (pin_a1),
    .pin_a2 (pin_a2),
    .a0_hv  (a0_hv),
    .soft_q (soft_q),
    .perm_q (perm_q),
    .busy   (busy),
    .ack    (dec_ack),
    .kind   (dec_kind)
  );

  swp_wcycle_timer #(.CYCLES(WR_CYCLES)) u_tmr (
    .clk   (clk),
    .rst   (rst),
    .start (start_cyc),
    .busy  (busy),
    .last  (cyc_last)
  );

  swp_prot_reg u_prot (
    .clk       (clk),
    .rst       (rst),
    .init_soft (init_soft),
    .init_perm (init_perm),
    .apply     (cyc_last),
    .op        (pend_op),
    .soft_q    (soft_q),
    .perm_q    (perm_q),
    .upd       (reg_upd)
  );

  swp_page_ptr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ptr (
    .clk      (clk),
    .rst      (rst),
    .load     (addr_take),
    .load_val (addr_byte),
    .step     (data_take && sess == K_ARR_WR),
    .ptr      (ptr)
  );

  assign addr_take = !ctl_valid && addr_valid && takes_data(sess) && !got_addr;
  assign data_take = !ctl_valid && !addr_valid && data_valid &&
                     takes_data(sess) && got_addr;
  assign start_cyc = !ctl_valid && !addr_valid && !data_valid && stop_seen &&
                     takes_data(sess) && got_data;
  assign blocked   = hw_wp || ((soft_q || perm_q) && !ptr[HALF_BIT]);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_ack  <= 1'b0;
      addr_ack <= 1'b0;
      data_ack <= 1'b0;
      wr_en    <= 1'b0;
      wr_addr  <= '0;
      sess     <= K_NONE;
      pend_op  <= K_NONE;
      got_addr <= 1'b0;
      got_data <= 1'b0;
    end else begin
      ctl_ack  <= 1'b0;
      addr_ack <= 1'b0;
      data_ack <= 1'b0;
      wr_en    <= 1'b0;
      if (ctl_valid) begin
        ctl_ack  <= dec_ack;
        sess     <= dec_ack ? dec_kind : K_NONE;
        got_addr <= 1'b0;
        got_data <= 1'b0;
      end else if (addr_take) begin
        addr_ack <= 1'b1;
        got_addr <= 1'b1;
      end else if (data_take) begin
        data_ack <= 1'b1;
        got_data <= 1'b1;
        if (sess == K_ARR_WR) begin
          wr_en   <= !blocked;
          wr_addr <= ptr;
        end
      end else if (stop_seen) begin
        sess     <= K_NONE;
        got_addr <= 1'b0;
        got_data <= 1'b0;
        if (start_cyc) pend_op <= sess;
      end
    end
  end

endmodule

// File: rtl/swp_ctrl_chk.sv
module swp_ctrl_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              ctl_valid,
  input logic [3:0]        ctl_code,
  input logic              busy,
  input logic              ctl_ack,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              hw_wp,
  input logic              soft_q,
  input logic              perm_q,
  input logic              reg_upd
);

  assert_busy_mute_R6: assert property (@(posedge clk) disable iff (rst)
    (busy && ctl_valid) |=> !ctl_ack);

  assert_lock_mute_R9: assert property (@(posedge clk) disable iff (rst)
    (perm_q && ctl_valid && ctl_code == 4'b0110) |=> !ctl_ack);

  assert_hw_block_R5: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> !$past(hw_wp));

  assert_low_block_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_addr[ADDR_W-1]) |-> !$past(soft_q || perm_q));

  assert_lock_hold_R9: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(perm_q)) |-> perm_q);

  assert_upd_end_R11: assert property (@(posedge clk) disable iff (rst)
    reg_upd |-> $fell(busy));

  assert_soft_move_R11: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && soft_q != $past(soft_q)) |-> reg_upd);

endmodule

bind swp_ctrl swp_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .ctl_valid (ctl_valid),
  .ctl_code  (ctl_code),
  .busy      (busy),
  .ctl_ack   (ctl_ack),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .hw_wp     (hw_wp),
  .soft_q    (soft_q),
  .perm_q    (perm_q),
  .reg_upd   (reg_upd)
);

// File: tb/sim_swp_ctrl.sv
module sim_swp_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int W          = 24;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       init_soft = 1'b0, init_perm = 1'b0;
  logic       ctl_valid = 1'b0, ctl_rw = 1'b0;
  logic [3:0] ctl_code = '0;
  logic [2:0] ctl_cs = '0;
  logic       addr_valid = 1'b0, data_valid = 1'b0, stop_seen = 1'b0;
  logic [7:0] addr_byte = '0;
  logic       pin_a0 = 1'b1, pin_a1 = 1'b0, pin_a2 = 1'b0;
  logic       a0_hv = 1'b0, hw_wp = 1'b0;
  logic       ctl_ack, addr_ack, data_ack, wr_en, busy, reg_upd;
  logic [7:0] wr_addr;

  int total = 0;
  int bad   = 0;

  typedef struct {
    string      tag;
    logic       c, a, d, w;
    logic [7:0] wa;
  } exp_t;

  exp_t exp_q[$];
  logic due_q = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  swp_ctrl #(.ADDR_W(8), .PAGE_W(4), .WR_CYCLES(W)) u0 (
    .clk(clk), .rst(rst), .init_soft(init_soft), .init_perm(init_perm),
    .ctl_valid(ctl_valid), .ctl_code(ctl_code), .ctl_cs(ctl_cs), .ctl_rw(ctl_rw),
    .addr_valid(addr_valid), .addr_byte(addr_byte), .data_valid(data_valid),
    .stop_seen(stop_seen), .pin_a0(pin_a0), .pin_a1(pin_a1), .pin_a2(pin_a2),
    .a0_hv(a0_hv), .hw_wp(hw_wp), .ctl_ack(ctl_ack), .addr_ack(addr_ack),
    .data_ack(data_ack), .wr_en(wr_en), .wr_addr(wr_addr), .busy(busy),
    .reg_upd(reg_upd)
  );

  task automatic chk(input logic ok, input string tag, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // scoreboard monitor: one response cycle after each byte event
  always @(posedge clk) due_q <= ctl_valid | addr_valid | data_valid;

  always @(negedge clk) begin
    if (due_q) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "scoreboard underflow", 0, 1);
      end else begin
        exp_t e;
        logic ok;
        e  = exp_q.pop_front();
        ok = (ctl_ack == e.c) && (addr_ack == e.a) && (data_ack == e.d) &&
             (wr_en == e.w) && (!e.w || wr_addr == e.wa);
        chk(ok, e.tag, int'({ctl_ack, addr_ack, data_ack, wr_en, wr_addr}),
            int'({e.c, e.a, e.d, e.w, (e.w ? e.wa : wr_addr)}));
      end
    end
  end

  task automatic push(input string tag, input logic c, input logic a,
                      input logic d, input logic w, input logic [7:0] wa);
    exp_t e;
    e.tag = tag; e.c = c; e.a = a; e.d = d; e.w = w; e.wa = wa;
    exp_q.push_back(e);
  endtask

  task automatic do_ctl(input logic [3:0] code, input logic [2:0] cs, input logic rw,
                        input logic expc, input string tag);
    @(negedge clk);
    ctl_code = code; ctl_cs = cs; ctl_rw = rw; ctl_valid = 1'b1;
    push(tag, expc, 1'b0, 1'b0, 1'b0, 8'h00);
    @(negedge clk);
    ctl_valid = 1'b0;
  endtask

  task automatic do_addr(input logic [7:0] a, input logic expa, input string tag);
    @(negedge clk);
    addr_byte = a; addr_valid = 1'b1;
    push(tag, 1'b0, expa, 1'b0, 1'b0, 8'h00);
    @(negedge clk);
    addr_valid = 1'b0;
  endtask

  task automatic do_data(input logic expd, input logic expw, input logic [7:0] wa,
                         input string tag);
    @(negedge clk);
    data_valid = 1'b1;
    push(tag, 1'b0, 1'b0, expd, expw, wa);
    @(negedge clk);
    data_valid = 1'b0;
  endtask

  task automatic do_stop();
    @(negedge clk);
    stop_seen = 1'b1;
    @(negedge clk);
    stop_seen = 1'b0;
  endtask

  // counts the negedges with busy high, then checks reg_upd where busy fell
  task automatic wait_cycle(input int exp_n, input logic exp_upd, input string tag);
    int n = 0;
    while (busy && n < 1000) begin
      n++;
      @(negedge clk);
    end
    chk(n == exp_n, {tag, " cycle length"}, n, exp_n);
    chk(reg_upd == exp_upd, {tag, " reg_upd"}, int'(reg_upd), int'(exp_upd));
  endtask

  task automatic arr_write(input logic [7:0] a, input logic expw, input string tag);
    do_ctl(4'b1010, 3'b001, 1'b0, 1'b1, tag);
    do_addr(a, 1'b1, tag);
    do_data(1'b1, expw, a, tag);
    do_stop();
    wait_cycle(W, 1'b0, tag);
  endtask

  task automatic query(input logic [2:0] cs, input logic hv, input logic a1,
                       input logic expc, input string tag);
    a0_hv = hv; pin_a1 = a1;
    do_ctl(4'b0110, cs, 1'b1, expc, tag);
    do_stop();
    wait_cycle(0, 1'b0, tag);
    a0_hv = 1'b0; pin_a1 = 1'b0;
  endtask

  task automatic prot_cmd(input logic [2:0] cs, input logic hv, input logic a1,
                          input string tag);
    a0_hv = hv; pin_a1 = a1;
    do_ctl(4'b0110, cs, 1'b0, 1'b1, tag);
    do_addr(8'h5A, 1'b1, tag);
    do_data(1'b1, 1'b0, 8'h00, tag);
    do_stop();
    a0_hv = 1'b0; pin_a1 = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk({ctl_ack, addr_ack, data_ack, wr_en, busy, reg_upd} == 6'b0,
        "R1 outputs after reset", int'({ctl_ack, addr_ack, data_ack, wr_en, busy, reg_upd}), 0);

    // R2 R4 R6: plain byte write to the low half, unprotected
    arr_write(8'h05, 1'b1, "R2 R4 unprotected write 05h");

    // R2 R12: chip-select mismatch, then address ignored
    do_ctl(4'b1010, 3'b101, 1'b0, 1'b0, "R2 cs mismatch");
    do_addr(8'h11, 1'b0, "R12 addr after nack");
    do_stop();
    wait_cycle(0, 1'b0, "R12 no cycle after nack");

    // R3: page write wraps within the page
    do_ctl(4'b1010, 3'b001, 1'b0, 1'b1, "R3 page ctl");
    do_addr(8'h8E, 1'b1, "R3 page addr");
    do_data(1'b1, 1'b1, 8'h8E, "R3 byte 0");
    do_data(1'b1, 1'b1, 8'h8F, "R3 byte 1");
    do_data(1'b1, 1'b1, 8'h80, "R3 wrap byte 2");
    do_stop();
    wait_cycle(W, 1'b0, "R3 page");

    // R6: stop with no data byte starts no cycle
    do_ctl(4'b1010, 3'b001, 1'b0, 1'b1, "R6 ctl no data");
    do_addr(8'h40, 1'b1, "R6 addr no data");
    do_stop();
    wait_cycle(0, 1'b0, "R6 stop without data");

    // R10: queries while unprotected
    query(3'b001, 1'b1, 1'b0, 1'b1, "R10 set query unprot");
    query(3'b011, 1'b1, 1'b1, 1'b1, "R10 clr query unprot");
    query(3'b001, 1'b0, 1'b0, 1'b1, "R10 lock query unprot");

    // R7 R11 R6: set-protect, control byte rejected while busy
    prot_cmd(3'b001, 1'b1, 1'b0, "R7 set");
    do_ctl(4'b1010, 3'b001, 1'b0, 1'b0, "R6 ctl while busy");
    wait_cycle(W - 2, 1'b1, "R7 R11 set cycle");

    // R7: second set rejected, no cycle
    a0_hv = 1'b1;
    do_ctl(4'b0110, 3'b001, 1'b0, 1'b0, "R7 repeat set");
    do_addr(8'h00, 1'b0, "R7 R12 addr after repeat set");
    do_stop();
    wait_cycle(0, 1'b0, "R7 repeat set");
    a0_hv = 1'b0;

    // R10: queries while soft-protected
    query(3'b001, 1'b1, 1'b0, 1'b0, "R10 set query soft");
    query(3'b011, 1'b1, 1'b1, 1'b1, "R10 clr query soft");
    query(3'b001, 1'b0, 1'b0, 1'b1, "R10 lock query soft");

    // R4: low half blocked, high half written
    arr_write(8'h10, 1'b0, "R4 soft low write");
    arr_write(8'h90, 1'b1, "R4 soft high write");

    // R8: clear-protect
    prot_cmd(3'b011, 1'b1, 1'b1, "R8 clear");
    wait_cycle(W, 1'b1, "R8 R11 clear cycle");
    arr_write(8'h10, 1'b1, "R8 low write after clear");

    // R5: hardware pin blocks everything, cycle still runs
    hw_wp = 1'b1;
    arr_write(8'hA0, 1'b0, "R5 hw high");
    arr_write(8'h20, 1'b0, "R5 hw low");
    hw_wp = 1'b0;

    // R9: permanent lock
    prot_cmd(3'b001, 1'b0, 1'b0, "R9 lock");
    wait_cycle(W, 1'b1, "R9 R11 lock cycle");
    a0_hv = 1'b1; pin_a1 = 1'b1;
    do_ctl(4'b0110, 3'b011, 1'b0, 1'b0, "R9 clear after lock");
    do_stop();
    wait_cycle(0, 1'b0, "R9 clear after lock");
    a0_hv = 1'b0; pin_a1 = 1'b0;
    do_ctl(4'b0110, 3'b001, 1'b0, 1'b0, "R9 lock again");
    do_stop();
    wait_cycle(0, 1'b0, "R9 lock again");
    query(3'b011, 1'b1, 1'b1, 1'b0, "R10 clr query locked");
    query(3'b001, 1'b0, 1'b0, 1'b0, "R10 lock query locked");
    arr_write(8'h20, 1'b0, "R4 R9 locked low write");
    arr_write(8'hC3, 1'b1, "R4 R9 locked high write");

    // R1: reset loads a stored image with soft set, lock clear
    init_soft = 1'b1; init_perm = 1'b0;
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk({ctl_ack, busy, reg_upd} == 3'b0, "R1 outputs after image reset",
        int'({ctl_ack, busy, reg_upd}), 0);
    query(3'b001, 1'b1, 1'b0, 1'b0, "R1 R10 set query after image");
    arr_write(8'h30, 1'b0, "R1 R4 low write after image");
    arr_write(8'hB0, 1'b1, "R1 R4 high write after image");

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule